// File: doc/BRIEF.md
# Sparse Power-of-Two Coefficient Multiplier

This block multiplies a signed fixed-point sample by a coefficient held as a short list of signed power-of-two terms. Each term is a plus or minus weight of 2^-e, with e in 1..MAX_DEPTH. Each active term costs one barrel shift of the sample and one add or subtract. The block has no hardware multiplier. A pipelined two-level adder tree sums the shifted copies. The result is exact: the output is an integer equal to the true product scaled by 2^MAX_DEPTH, so no fractional bit is ever dropped.

The term list sits in a register that is written at run time through a load strobe. A sample entering in the same cycle as a load still sees the previous list. Samples already inside the pipeline keep the terms they were captured with. A single valid strobe travels with the data, and there is no back-pressure. The exponent field is four bits wide, so MAX_DEPTH must stay at or below 15.

Top module: `sopot_mult`

## Requirements
- R1: On a valid sample, the product equals the sum over active slots of (sample × 2^(MAX_DEPTH−e)). The term is subtracted when its negate bit is 1 and added when it is 0. A zero sample always gives a zero product.
- R2: Slot i of `termList` occupies bits [6i+5:6i]. Within a slot, bit 5 is the valid flag, bit 4 is the negate flag and bits 3:0 hold the exponent e.
- R3: The product is DATA_W+MAX_DEPTH+2 bits wide (30 by default) and never overflows. This holds even with a sample of −32768 and all four slots set to e=1, which gives a magnitude of 2^28.
- R4: A slot whose valid flag is 0 contributes zero, whatever its sign and exponent are.
- R5: A slot with valid set but an exponent of 0 or above MAX_DEPTH also contributes zero.
- R6: `outValid` rises exactly two cycles after each `inValid`, and at no other time.
- R7: Asserting `loadStrobe` replaces the whole term list. A sample presented in the same cycle uses the old list, and every later sample uses the new one.
- R8: A load does not alter the result of any sample that was accepted before it.
- R9: While `outValid` is low, `product` holds its last value.
- R10: After reset, `outValid` is 0, `product` is 0 and every slot is invalid, so a sample taken before any load yields 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| loadStrobe | input | 1 | Captures `termList` into the term register |
| termList | input | 24 | Packed term slots, 6 bits each |
| inValid | input | 1 | Sample strobe |
| sample | input | 16 | Two's complement input sample |
| outValid | output | 1 | Result strobe, two cycles after `inValid` |
| product | output | 30 | Signed product scaled by 2^MAX_DEPTH |

## Verification
The hardest situations to reach from the ports are those where a list load meets samples in flight. One is a load in the very cycle a sample enters. Another is a load in the cycle just after a sample, while that sample is still between the two adder stages. The driver task lets a load and a sample share a cycle and lets the bench issue samples back to back. The bench also interleaves random loads into a dense random sample stream, so both orderings occur many times. The scoreboard keeps its own copy of the list and updates it only after computing the expected value of a same-cycle sample. Directed cases cover the extreme magnitude, invalid slots and out-of-range exponents.

// File: rtl/sopot_pkg.sv
package sopot_pkg;

  localparam int EXP_W  = 4;
  localparam int SLOT_W = EXP_W + 2;

  typedef struct packed {
    logic             valid;
    logic             neg;
    logic [EXP_W-1:0] exp;
  } term_t;

  typedef struct packed {
    logic stage1En;
    logic stage2En;
  } pipe_ctrl_t;

endpackage

// File: rtl/sopot_ctrl.sv
module sopot_ctrl
  import sopot_pkg::*;
#(
  parameter int NUM_TERMS = 4
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        loadStrobe,
  input  term_t [NUM_TERMS-1:0]       termsIn,
  input  logic                        inValid,
  output term_t [NUM_TERMS-1:0]       termReg,
  output pipe_ctrl_t                  strobes,
  output logic                        outValid
);

  logic midValid;
  logic lastValid;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      termReg   <= '0;
      midValid  <= 1'b0;
      lastValid <= 1'b0;
    end else begin
      if (loadStrobe) termReg <= termsIn;
      midValid  <= inValid;
      lastValid <= midValid;
    end
  end

  always_comb begin
    strobes.stage1En = inValid;
    strobes.stage2En = midValid;
  end

  assign outValid = lastValid;

  assert_latency_R6: assert property (@(posedge clk) disable iff (!rstN)
    inValid |-> ##2 outValid);

  assert_no_spurious_R6: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |-> ##2 !outValid);

  assert_terms_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    !loadStrobe |=> $stable(termReg));

endmodule

// File: rtl/sopot_term_unit.sv
module sopot_term_unit
  import sopot_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int MAX_DEPTH = 12,
  parameter int OUT_W     = DATA_W + MAX_DEPTH + 2
) (
  input  logic signed [DATA_W-1:0] sample,
  input  term_t                    term,
  output logic signed [OUT_W-1:0]  contribution
);

  localparam logic [EXP_W-1:0] DEPTH_CODE = EXP_W'(MAX_DEPTH);

  logic                    active;
  logic [EXP_W-1:0]        shiftAmt;
  logic signed [OUT_W-1:0] wide;
  logic signed [OUT_W-1:0] shifted;

  assign active   = term.valid && (term.exp != '0) && (term.exp <= DEPTH_CODE);
  assign shiftAmt = active ? (DEPTH_CODE - term.exp) : '0;
  assign wide     = {{(OUT_W-DATA_W){sample[DATA_W-1]}}, sample};
  assign shifted  = wide <<< shiftAmt;

  always_comb begin
    if (!active)       contribution = '0;
    else if (term.neg) contribution = -shifted;
    else               contribution = shifted;
  end

endmodule

// File: rtl/sopot_datapath.sv
module sopot_datapath
  import sopot_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int NUM_TERMS = 4,
  parameter int MAX_DEPTH = 12,
  parameter int OUT_W     = DATA_W + MAX_DEPTH + 2
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  pipe_ctrl_t                  strobes,
  input  term_t [NUM_TERMS-1:0]       termReg,
  input  logic signed [DATA_W-1:0]    sample,
  output logic signed [OUT_W-1:0]     product
);

  localparam int NUM_PAIRS = (NUM_TERMS + 1) / 2;
  localparam logic [EXP_W-1:0] DEPTH_CODE = EXP_W'(MAX_DEPTH);

  logic signed [OUT_W-1:0] contrib  [NUM_TERMS];
  logic signed [OUT_W-1:0] pairSum  [NUM_PAIRS];
  logic signed [OUT_W-1:0] partial  [NUM_PAIRS];
  logic signed [OUT_W-1:0] total;

  for (genvar t = 0; t < NUM_TERMS; t++) begin : g_term
    sopot_term_unit #(
      .DATA_W   (DATA_W),
      .MAX_DEPTH(MAX_DEPTH),
      .OUT_W    (OUT_W)
    ) u_term (
      .sample      (sample),
      .term        (termReg[t]),
      .contribution(contrib[t])
    );
  end

  for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
    if (2*p + 1 < NUM_TERMS) begin : g_two
      assign pairSum[p] = contrib[2*p] + contrib[2*p+1];
    end else begin : g_one
      assign pairSum[p] = contrib[2*p];
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                 partial[p] <= '0;
      else if (strobes.stage1En) partial[p] <= pairSum[p];
    end
  end

  always_comb begin
    total = '0;
    for (int p = 0; p < NUM_PAIRS; p++) total = total + partial[p];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 product <= '0;
    else if (strobes.stage2En) product <= total;
  end

  // Observation signals for the checks below
  logic noneValid;
  logic noneInRange;
  logic partialZero;

  always_comb begin
    noneValid   = 1'b1;
    noneInRange = 1'b1;
    for (int t = 0; t < NUM_TERMS; t++) begin
      if (termReg[t].valid) noneValid = 1'b0;
      if (termReg[t].exp != '0 && termReg[t].exp <= DEPTH_CODE) noneInRange = 1'b0;
    end
    partialZero = 1'b1;
    for (int p = 0; p < NUM_PAIRS; p++)
      if (partial[p] != '0) partialZero = 1'b0;
  end

  assert_invalid_zero_R4: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.stage1En && noneValid) |=> partialZero);

  assert_range_zero_R5: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.stage1En && noneInRange) |=> partialZero);

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.stage2En |=> $stable(product));

endmodule

// File: rtl/sopot_mult.sv
module sopot_mult
  import sopot_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int NUM_TERMS = 4,
  parameter int MAX_DEPTH = 12,
  localparam int OUT_W    = DATA_W + MAX_DEPTH + 2,
  localparam int LIST_W   = NUM_TERMS * SLOT_W
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     loadStrobe,
  input  logic [LIST_W-1:0]        termList,
  input  logic                     inValid,
  input  logic signed [DATA_W-1:0] sample,
  output logic                     outValid,
  output logic signed [OUT_W-1:0]  product
);

  localparam longint BOUND = longint'(NUM_TERMS) <<< (DATA_W + MAX_DEPTH - 2);

  term_t [NUM_TERMS-1:0] termsIn;
  term_t [NUM_TERMS-1:0] termReg;
  pipe_ctrl_t            strobes;

  assign termsIn = termList;

  sopot_ctrl #(
    .NUM_TERMS(NUM_TERMS)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .loadStrobe(loadStrobe),
    .termsIn   (termsIn),
    .inValid   (inValid),
    .termReg   (termReg),
    .strobes   (strobes),
    .outValid  (outValid)
  );

  sopot_datapath #(
    .DATA_W   (DATA_W),
    .NUM_TERMS(NUM_TERMS),
    .MAX_DEPTH(MAX_DEPTH),
    .OUT_W    (OUT_W)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strobes(strobes),
    .termReg(termReg),
    .sample (sample),
    .product(product)
  );

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (longint'(product) <= BOUND) && (longint'(product) >= -BOUND));

  assert_zero_sample_R1: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && sample == '0) |-> ##2 (product == '0));

endmodule

// File: tb/sopot_mult_test.sv
module sopot_mult_test;

  localparam int CLK_PERIOD = 10;
  localparam int DATA_W     = 16;
  localparam int MAX_DEPTH  = 12;
  localparam int OUT_W      = DATA_W + MAX_DEPTH + 2;
  localparam int LIST_W     = 24;

  logic                     clk = 1'b0;
  logic                     rstN = 1'b0;
  logic                     loadStrobe = 1'b0;
  logic [LIST_W-1:0]        termList = '0;
  logic                     inValid = 1'b0;
  logic signed [DATA_W-1:0] sample = '0;
  logic                     outValid;
  logic signed [OUT_W-1:0]  product;

  int     compared = 0;
  int     mismatched = 0;
  longint cyc = 0;
  bit     monOn = 1'b0;
  longint lastProduct = 0;
  longint expQ[$];
  longint issueQ[$];
  string  tagQ[$];
  logic [LIST_W-1:0] modelTerms = '0;

  sopot_mult uut (
    .clk       (clk),
    .rstN      (rstN),
    .loadStrobe(loadStrobe),
    .termList  (termList),
    .inValid   (inValid),
    .sample    (sample),
    .outValid  (outValid),
    .product   (product)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc++;

  task automatic check(bit ok, string tag, longint act, longint exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // R2 slot layout: {valid, negate, exponent[3:0]}, slot i at bits [6i+5:6i]
  function automatic logic [5:0] mk(bit v, bit n, int e);
    return {v, n, 4'(e)};
  endfunction

  function automatic longint model(logic [LIST_W-1:0] lst, logic signed [DATA_W-1:0] s);
    longint acc = 0;
    for (int i = 0; i < 4; i++) begin
      logic [5:0] t = lst[6*i +: 6];
      int e = int'(t[3:0]);
      if (t[5] && e >= 1 && e <= MAX_DEPTH) begin
        longint p = longint'(s) * (longint'(1) << (MAX_DEPTH - e));
        acc += t[4] ? -p : p;
      end
    end
    return acc;
  endfunction

  task automatic step(bit doLoad, logic [LIST_W-1:0] newList, bit doSample,
                      logic signed [DATA_W-1:0] s, string tag);
    @(negedge clk);
    loadStrobe = doLoad;
    if (doLoad) termList = newList;
    inValid = doSample;
    if (doSample) begin
      sample = s;
      expQ.push_back(model(modelTerms, s));
      issueQ.push_back(cyc);
      tagQ.push_back(tag);
    end
    if (doLoad) modelTerms = newList;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(1'b0, '0, 1'b0, '0, "");
  endtask

  // Monitor / scoreboard
  always @(negedge clk) begin
    longint e;
    longint iss;
    string  t;
    if (monOn) begin
      if (outValid) begin
        if (expQ.size() == 0) check(1'b0, "R6 unexpected outValid", 1, 0);
        else begin
          e   = expQ.pop_front();
          iss = issueQ.pop_front();
          t   = tagQ.pop_front();
          check(longint'(product) == e, t, longint'(product), e);
          check(cyc == iss + 2, "R6 latency", cyc - iss, 2);
          lastProduct = longint'(product);
        end
      end else begin
        check(longint'(product) == lastProduct, "R9 hold", longint'(product), lastProduct);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    mismatched++;
    compared++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(outValid == 1'b0, "R10 reset outValid", outValid, 0);
      check(product == '0, "R10 reset product", product, 0);
    end
    @(negedge clk);
    rstN = 1'b1;
    monOn = 1'b1;

    step(1'b0, '0, 1'b1, 16'sd1234, "R10 empty list after reset");
    idle(3);

    step(1'b1, {mk(0,0,0), mk(0,0,0), mk(0,0,0), mk(1,0,1)}, 1'b0, '0, "");
    step(1'b0, '0, 1'b1, 16'sd1000, "R1 single term e=1");
    step(1'b0, '0, 1'b1, -16'sd777, "R1 negative sample");
    step(1'b0, '0, 1'b1, 16'sd0, "R1 zero sample");
    step(1'b1, {mk(1,1,7), mk(1,0,3), mk(1,1,12), mk(1,0,2)}, 1'b0, '0, "");
    step(1'b0, '0, 1'b1, 16'sd12345, "R1 R2 mixed four-term list");
    idle(3);

    step(1'b1, {4{mk(1,1,1)}}, 1'b0, '0, "");
    step(1'b0, '0, 1'b1, -16'sd32768, "R3 max positive magnitude");
    step(1'b1, {4{mk(1,0,1)}}, 1'b0, '0, "");
    step(1'b0, '0, 1'b1, -16'sd32768, "R3 max negative magnitude");
    step(1'b1, {4{mk(1,0,12)}}, 1'b0, '0, "");
    step(1'b0, '0, 1'b1, 16'sd32767, "R3 finest depth e=12");
    idle(3);

    step(1'b1, {4{mk(0,1,3)}}, 1'b0, '0, "");
    step(1'b0, '0, 1'b1, 16'sd5000, "R4 all slots invalid");
    step(1'b1, {mk(0,0,1), mk(0,1,5), mk(0,0,1), mk(1,0,2)}, 1'b0, '0, "");
    step(1'b0, '0, 1'b1, 16'sd4096, "R4 invalid slots beside one valid");
    step(1'b1, {mk(1,0,0), mk(1,1,13), mk(1,0,15), mk(1,1,14)}, 1'b0, '0, "");
    step(1'b0, '0, 1'b1, -16'sd9999, "R5 out-of-range exponents");
    step(1'b1, {mk(1,0,0), mk(1,1,13), mk(1,0,12), mk(1,0,15)}, 1'b0, '0, "");
    step(1'b0, '0, 1'b1, 16'sd321, "R5 one in-range among out-of-range");
    idle(3);

    step(1'b1, {mk(0,0,0), mk(0,0,0), mk(0,0,0), mk(1,0,4)}, 1'b0, '0, "");
    step(1'b1, {mk(0,0,0), mk(0,0,0), mk(0,0,0), mk(1,1,1)}, 1'b1, 16'sd2000,
         "R7 sample in load cycle uses old list");
    step(1'b0, '0, 1'b1, 16'sd2000, "R7 next sample uses new list");
    step(1'b0, '0, 1'b1, 16'sd300, "R8 sample before in-flight load");
    step(1'b1, {mk(1,0,2), mk(0,0,0), mk(1,1,6), mk(0,0,0)}, 1'b0, '0, "");
    step(1'b0, '0, 1'b1, 16'sd300, "R8 sample after load");
    idle(3);

    for (int n = 0; n < 600; n++) begin
      bit doL = ($urandom % 10) == 0;
      bit doS = ($urandom % 10) < 7;
      logic [LIST_W-1:0] rl;
      for (int k = 0; k < 4; k++) rl[6*k +: 6] = 6'($urandom);
      step(doL, rl, doS, DATA_W'($urandom), "R1 R7 R8 random stream");
    end

    idle(6);
    check(expQ.size() == 0, "R6 all results delivered", expQ.size(), 0);
    monOn = 1'b0;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule